// File: doc/BRIEF.md
# Serial Flash Instruction Fetcher

This block feeds a stack-machine decoder straight from an external serial NOR flash, with no instruction cache and no instruction RAM. The core presents a 24-bit program address with a request and a kind bit that asks for either one opcode byte or one 32-bit immediate. The fetcher opens a flash read transaction and clocks in the requested bytes. It then hands back the byte zero-extended, or the four bytes packed into a word with the lowest address in the low byte. A single-cycle valid strobe marks the result, and the advanced program counter comes with it.

Each request is a complete transaction. Chip select falls, the standard read command goes out followed by the address, and a fixed number of idle wait cycles covers the device's access time. Then the data bytes are shifted in, and chip select rises again. The serial clock runs at half the system clock, in SPI mode 0. While a transaction is in flight the block drops ready and takes no new request.

Top module: `xip_fetch`

## Requirements
- R1: While reset is asserted and after it is released, ready_o is 1, cs_no is 1, sck_o is 0, valid_o is 0 and pc_o is 0.
- R2: Every transaction sends the byte 0x03 and then the 24-bit requested address, each most significant bit first. mosi_o only changes while sck_o is low, so that the flash can sample it on the rising edge.
- R3: sck_o toggles every system clock while bits are being shifted, starting low: one low cycle then one high cycle per bit. It stays low at all other times and is never high while cs_no is high.
- R4: After the last address bit, WAIT_CYC (default 2) cycles pass with cs_no low and sck_o low before the first data bit clock.
- R5: With kind_i = 0 (opcode), one byte is read. valid_o is high for exactly one cycle, 67 + 16 = 83 cycles after the cycle in which the request was accepted. data_o holds the byte in bits 7:0 and zero in bits 31:8.
- R6: With kind_i = 1 (immediate), four consecutive bytes are read in one transaction. The byte from the requested address lands in data_o[7:0] and the byte from address+3 lands in data_o[31:24]. valid_o rises once, 67 + 64 = 131 cycles after acceptance.
- R7: Nothing is cached. A repeated request for the same address runs a new flash transaction with a new command and address.
- R8: pc_o changes only in the valid_o cycle. It then equals the request address plus 1 for an opcode or plus 4 for an immediate, modulo 2^24.
- R9: cs_no is low from the cycle after acceptance until the last data bit, and it is high in the valid_o cycle and whenever the block is idle.
- R10: ready_o is low from the cycle after acceptance through the valid_o cycle. A request presented in that window is ignored and never reaches the flash.
- R11: Addresses wrap at 24 bits. An immediate at 0xFFFFFE reads the bytes at 0xFFFFFE, 0xFFFFFF, 0x000000 and 0x000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request, taken when ready_o is high |
| kind_i | input | 1 | 0 = opcode byte, 1 = 32-bit immediate |
| addr_i | input | 24 | Program address of the first byte |
| ready_o | output | 1 | Idle and able to take a request |
| valid_o | output | 1 | One-cycle strobe, data_o and pc_o are new |
| data_o | output | 32 | Fetched byte (zero-extended) or immediate word |
| pc_o | output | 24 | Address following the fetched item |
| sck_o | output | 1 | Serial clock to flash |
| cs_no | output | 1 | Flash chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
A wrong phase or bit count inside the fetcher shows up on the serial pins first. A bad shift register or bit counter gives a wrong command or address in the header that the flash model decodes after 32 clock edges, or moves the wait gap visibly within a few cycles. A wrong byte counter or lane index changes how long chip select stays low and where the valid strobe lands, and the cycle-exact model flags this in the cycle concerned. A wrong program counter offset appears at the next valid strobe. Requests injected while busy would show as an early ready or as a second header carrying the wrong address.

// File: rtl/xip_pkg.sv
package xip_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WAIT, ST_DATA, ST_DONE
  } xip_state_e;

  localparam logic [7:0] READ_CMD = 8'h03;
endpackage

// File: rtl/xip_sck_gen.sv
// Half-rate serial clock; tick marks the end of each high phase (shift/sample point).
module xip_sck_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic tick_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sck_q <= 1'b0;
    else if (run_i) sck_q <= ~sck_q;
    else            sck_q <= 1'b0;
  end

  assign sck_o  = sck_q;
  assign tick_o = run_i & sck_q;
endmodule

// File: rtl/xip_word_asm.sv
// Collects serial bits MSB first into bytes, bytes into word lanes lowest first.
module xip_word_asm #(
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    tick_i,
  input  logic                    bit_i,
  output logic                    byte_done_o,
  output logic [WORD_BYTES*8-1:0] word_o
);
  localparam int IDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [2:0]       bit_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [6:0]       sh_q;

  assign byte_done_o = tick_i && (bit_cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
    end else if (clr_i) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
    end else if (tick_i) begin
      sh_q      <= {sh_q[5:0], bit_i};
      bit_cnt_q <= bit_cnt_q + 3'd1;
      if (bit_cnt_q == 3'd7) idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 lane_q <= '0;
      else if (clr_i)                              lane_q <= '0;
      else if (byte_done_o && idx_q == IDX_W'(g))  lane_q <= {sh_q, bit_i};
    end
    assign word_o[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/xip_fetch.sv
module xip_fetch #(
  parameter int ADDR_W     = 24,
  parameter int WORD_BYTES = 4,
  parameter int WAIT_CYC   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    kind_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    ready_o,
  output logic                    valid_o,
  output logic [WORD_BYTES*8-1:0] data_o,
  output logic [ADDR_W-1:0]       pc_o,
  output logic                    sck_o,
  output logic                    cs_no,
  output logic                    mosi_o,
  input  logic                    miso_i
);
  import xip_pkg::*;

  localparam int HDR_BITS = 8 + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS);
  localparam int LEFT_W   = $clog2(WORD_BYTES + 1);
  localparam int WAIT_W   = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  xip_state_e          state_q;
  logic [HDR_BITS-1:0] tx_q;
  logic [CNT_W-1:0]    bit_cnt_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [LEFT_W-1:0]   left_q;
  logic                kind_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   pc_q;
  logic                run, tick, byte_done;

  assign run = (state_q == ST_CMD) || (state_q == ST_DATA);

  xip_sck_gen u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sck_o  (sck_o),
    .tick_o (tick)
  );

  xip_word_asm #(.WORD_BYTES(WORD_BYTES)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_IDLE),
    .tick_i      (tick && state_q == ST_DATA),
    .bit_i       (miso_i),
    .byte_done_o (byte_done),
    .word_o      (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tx_q      <= '0;
      bit_cnt_q <= '0;
      wait_q    <= '0;
      left_q    <= '0;
      kind_q    <= 1'b0;
      addr_q    <= '0;
      pc_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          tx_q      <= {READ_CMD, addr_i};
          addr_q    <= addr_i;
          kind_q    <= kind_i;
          bit_cnt_q <= '0;
          left_q    <= kind_i ? LEFT_W'(WORD_BYTES) : LEFT_W'(1);
          state_q   <= ST_CMD;
        end
        ST_CMD: if (tick) begin
          tx_q      <= {tx_q[HDR_BITS-2:0], 1'b0};
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          if (bit_cnt_q == CNT_W'(HDR_BITS - 1)) begin
            wait_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          wait_q <= wait_q + WAIT_W'(1);
          if (wait_q == WAIT_W'(WAIT_CYC - 1)) state_q <= ST_DATA;
        end
        ST_DATA: if (byte_done) begin
          left_q <= left_q - LEFT_W'(1);
          if (left_q == LEFT_W'(1)) begin
            pc_q    <= addr_q + (kind_q ? ADDR_W'(WORD_BYTES) : ADDR_W'(1));
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign valid_o = (state_q == ST_DONE);
  assign cs_no   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign mosi_o  = (state_q == ST_CMD) && tx_q[HDR_BITS-1];
  assign pc_o    = pc_q;
endmodule

// File: rtl/xip_fetch_chk.sv
module xip_fetch_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              valid_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              sck_o,
  input logic              cs_no,
  input logic              mosi_o
);
  p_idle_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);
  p_valid_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !sck_o));
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_sck_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);
  p_sck_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);
  p_mosi_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));
  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> (!ready_o && !cs_no));
  p_pc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pc_o));
endmodule

bind xip_fetch xip_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ready_o (ready_o),
  .valid_o (valid_o),
  .pc_o    (pc_o),
  .sck_o   (sck_o),
  .cs_no   (cs_no),
  .mosi_o  (mosi_o)
);

// File: tb/xip_fetch_test.sv
module xip_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        kind = 1'b0;
  logic [23:0] addr = '0;
  logic        miso = 1'b0;
  logic        ready, valid, sck, cs_n, mosi;
  logic [31:0] data;
  logic [23:0] pc;

  int n_chk = 0, n_fail = 0, cyc = 0, hdr_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  xip_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .ready_o(ready), .valid_o(valid), .data_o(data), .pc_o(pc),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model, cycle by cycle
  int          t = 0, m_total = 0;
  logic [23:0] m_addr = '0, m_pc = '0;
  logic        m_kind = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ready == 1'b1, "R1 ready", ready, 1);
      chk(cs_n == 1'b1 && sck == 1'b0 && valid == 1'b0, "R1 pins", {cs_n, sck, valid}, 3'b100);
      chk(pc == 24'd0, "R1 pc", pc, 0);
    end else if (t == 0) begin
      chk(ready == 1'b1, "R10 idle ready", ready, 1);
      chk(cs_n == 1'b1, "R9 idle cs", cs_n, 1);
      chk(valid == 1'b0 && sck == 1'b0, "R3 idle sck/valid", {sck, valid}, 0);
      chk(pc == m_pc, "R8 pc hold", pc, m_pc);
      if (req) begin
        m_addr  = addr;
        m_kind  = kind;
        m_total = 67 + 16 * (kind ? 4 : 1);
        t = 1;
      end
    end else if (t < m_total) begin
      automatic bit es = (t <= 64) ? (t % 2 == 0) : (t <= 66) ? 1'b0 : ((t - 67) % 2 == 1);
      chk(ready == 1'b0, "R10 busy ready", ready, 0);
      chk(cs_n == 1'b0, "R9 cs low", cs_n, 0);
      chk(valid == 1'b0, m_kind ? "R6 early valid" : "R5 early valid", valid, 0);
      chk(sck == es, (t == 65 || t == 66) ? "R4 wait sck" : "R3 sck phase", sck, es);
      t++;
    end else begin
      automatic logic [31:0] ed;
      automatic logic [23:0] ep;
      ed = m_kind ? {fbyte(24'(m_addr + 3)), fbyte(24'(m_addr + 2)),
                     fbyte(24'(m_addr + 1)), fbyte(m_addr)}
                  : {24'd0, fbyte(m_addr)};
      ep = 24'(m_addr + (m_kind ? 4 : 1));
      chk(valid == 1'b1, m_kind ? "R6 valid" : "R5 valid", valid, 1);
      chk(data == ed, m_kind ? "R6 data R11" : "R5 data", data, ed);
      chk(pc == ep, "R8 pc R11", pc, ep);
      chk(cs_n == 1'b1 && ready == 1'b0, "R9 R10 done", {cs_n, ready}, 2'b10);
      m_pc = ep;
      t = 0;
    end
  end

  // behavioural flash responder
  int          rises = 0, obit = 0;
  logic [31:0] hdr = '0;
  logic        sck_prev = 1'b0;

  always @(negedge clk) begin
    if (cs_n) begin
      rises = 0;
      obit  = 0;
    end else if (sck && !sck_prev) begin
      rises++;
      if (rises <= 32) hdr = {hdr[30:0], mosi};
      if (rises == 32) begin
        hdr_cnt++;
        chk(hdr[31:24] == 8'h03, "R2 command", hdr[31:24], 8'h03);
        chk(hdr[23:0] == m_addr, "R2 R10 address", hdr[23:0], m_addr);
      end
    end else if (!sck && sck_prev && rises >= 32) begin
      automatic logic [7:0] b = fbyte(24'(m_addr + obit / 8));
      miso = b[7 - (obit % 8)];
      obit++;
    end
    sck_prev = sck;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      summary();
    end
  end

  task automatic fetch(input logic [23:0] a, input logic k);
    @(posedge clk); #2;
    req = 1'b1; addr = a; kind = k;
    do @(negedge clk); while (!ready);
    @(posedge clk); #2;
    req = 1'b0;
    do @(negedge clk); while (!valid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    fetch(24'h000010, 1'b0);          // R5
    fetch(24'h123456, 1'b1);          // R6
    fetch(24'hFFFFFF, 1'b0);          // R8 R11 pc wrap
    fetch(24'hFFFFFE, 1'b1);          // R11 flash wrap
    begin                              // R7 no caching
      automatic int h0 = hdr_cnt;
      fetch(24'h0000A7, 1'b1);
      fetch(24'h0000A7, 1'b1);
      chk(hdr_cnt == h0 + 2, "R7 refetch", hdr_cnt, h0 + 2);
    end
    begin                              // R10 request while busy
      @(posedge clk); #2;
      req = 1'b1; addr = 24'h000100; kind = 1'b1;
      do @(negedge clk); while (!ready);
      @(posedge clk); #2;
      req = 1'b0;
      repeat (10) @(posedge clk);
      #2 req = 1'b1; addr = 24'hABCDEF; kind = 1'b0;
      repeat (30) @(posedge clk);
      #2 req = 1'b0;
      do @(negedge clk); while (!valid);
    end
    fetch(24'h7F00C3, 1'b0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule